// File: doc/BRIEF.md
# Low-Power Interrupt Capture Controller

This block watches a parameterised group of interrupt lines while the main interrupt controller is switched off. Each line passes through a two-flop synchroniser. It is then qualified by its own mask, sensitivity (edge or level) and polarity bits. A qualifying event sets a sticky status bit, and the OR of all status bits drives a wake output. Software reaches the block over a simple 32-bit register bus. On resume it can request a one-cycle flush that presents the captured status vector to the logic that re-raises those interrupts in the main controller.

A small bus state machine decides how each access is handled. In `ST_IDLE` a read or write request is accepted. A plain access then moves to `ST_RESP`, where `reg_ready` is high for one cycle. A control write with the soft-reset bit moves to `ST_SRST`, which restores every register in one cycle. A control write with the flush bit (and no soft reset) moves to `ST_FLUSH`, which pulses the flush output. Both of these states then go on to `ST_RESP`, and `ST_RESP` always returns to `ST_IDLE`.

Top module: `wake_irq_catcher`

## Requirements
- R1: After reset, the status and sensitivity banks read 0 and the control word reads 0. The mask bank reads all ones for existing lines, the polarity bank reads all ones for existing lines, and `wake_o` is low.
- R2: Bank byte offsets are: status 0x000, acknowledge 0x080, mask 0x100, mask-set 0x180, mask-clear 0x200, sensitivity 0x280, sens-set 0x300, sens-clear 0x380, polarity 0x400, pol-set 0x480, pol-clear 0x500, control 0x600. Line n is bit n mod 32 of word n/32, at offset base + 4*(n/32). Bits above the last line read 0.
- R3: A write to a base view replaces the whole word. A write to a set alias sets only the bits written as 1, and a write to a clear alias clears only the bits written as 1. Set and clear aliases read back the base view.
- R4: A status bit can be set only while control bit 0 (enable) is 1 and the line's mask bit is 0.
- R5: With sensitivity bit 0 (edge), polarity 1 captures a rising edge and polarity 0 captures a falling edge. A steady level captures nothing.
- R6: With sensitivity bit 1 (level), the line captures while it sits at its active level (high for polarity 1, low for polarity 0). Control bit 1 (edge-only) forces edge detection on every line.
- R7: Writing 1 to an acknowledge bit clears that status bit. If a capture hits the same bit in the same cycle, the capture wins.
- R8: `wake_o` and control bit 31 (read-only) are both the OR of all status bits.
- R9: Writing control bit 2 (flush) gives exactly one cycle of `flush_pulse_o`, with `pending_o` equal to the status vector. At all other times `pending_o` is 0, and bit 2 reads back 0.
- R10: Writing control bit 20 (soft reset) restores status, control, mask, sensitivity and polarity to their R1 values in one cycle. The bit reads back 0, and soft reset takes precedence over flush.
- R11: `reg_ready` is high for one cycle: one cycle after a plain request is accepted, and two cycles after a flush or soft-reset write. Writes to the status bank or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt lines |
| reg_rd | input | 1 | Read request, taken in idle |
| reg_wr | input | 1 | Write request, taken in idle |
| reg_addr | input | 12 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with ready |
| reg_ready | output | 1 | One-cycle access completion |
| wake_o | output | 1 | Any status bit set |
| flush_pulse_o | output | 1 | One-cycle flush strobe |
| pending_o | output | NUM_LINES | Status vector during flush, else 0 |

## Verification
The capture path is driven with three kinds of input pattern: single rising transitions, single falling transitions, and lines held at a steady level. The held lines are acknowledged while still active. Rising against falling shows that polarity steers edge detection. Holding a line through an acknowledge separates level capture from edge capture, and it also shows that edge-only mode overrides the sensitivity bit. The same transitions on a masked line, and with enable off, show that qualification gates capture. Lines in the first word, a middle word and the partial last word check the word and bit layout and the zero fill above the last line.

// File: rtl/wic_pkg.sv
package wic_pkg;
    // bank selector = byte address bits [11:7]
    typedef enum logic [4:0] {
        BK_STAT = 5'd0,  BK_ACK  = 5'd1,
        BK_MASK = 5'd2,  BK_MSET = 5'd3,  BK_MCLR = 5'd4,
        BK_SENS = 5'd5,  BK_SSET = 5'd6,  BK_SCLR = 5'd7,
        BK_POL  = 5'd8,  BK_PSET = 5'd9,  BK_PCLR = 5'd10,
        BK_CTRL = 5'd12
    } bank_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_RESP, ST_FLUSH, ST_SRST
    } bus_state_e;

    localparam int CB_EN    = 0;
    localparam int CB_EONLY = 1;
    localparam int CB_FLUSH = 2;
    localparam int CB_SRST  = 20;
    localparam int CB_EVENT = 31;
endpackage

// File: rtl/wic_sync.sv
module wic_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/wic_detect.sv
module wic_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         en,
    input  logic         edge_only,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] sens,
    input  logic [W-1:0] pol,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev;
    logic [W-1:0] edge_hit;
    logic [W-1:0] lvl_hit;
    logic [W-1:0] use_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    always_comb begin
        edge_hit = (pol & lvl & ~prev) | (~pol & ~lvl & prev);
        lvl_hit  = (pol & lvl) | (~pol & ~lvl);
        use_edge = {W{edge_only}} | ~sens;
        hit      = {W{en}} & ~mask &
                   ((use_edge & edge_hit) | (~use_edge & lvl_hit));
    end
endmodule

// File: rtl/wic_regs.sv
module wic_regs
    import wic_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd,
    input  logic         wr,
    input  logic [11:0]  addr,
    input  logic [31:0]  wdata,
    input  logic [W-1:0] hit,
    output logic [31:0]  rdata,
    output logic         ready,
    output logic [W-1:0] mask,
    output logic [W-1:0] sens,
    output logic [W-1:0] pol,
    output logic         en,
    output logic         edge_only,
    output logic [W-1:0] status,
    output logic         flush_pulse,
    output logic [W-1:0] pending,
    output logic         srst_fire
);
    localparam int NW = (W + 31) / 32;
    localparam int PW = NW * 32;

    bus_state_e   state, state_nx;
    logic [4:0]   bsel;
    logic [4:0]   word;
    logic         take_wr;
    logic [W-1:0] wd, wsel;
    logic [W-1:0] mask_d, sens_d, pol_d, status_d, ack_clr;
    logic         en_d, eo_d;
    logic [31:0]  rmux;
    logic         unused_addr_lsb;

    assign bsel            = addr[11:7];
    assign word            = addr[6:2];
    assign unused_addr_lsb = ^addr[1:0];
    assign take_wr         = (state == ST_IDLE) && wr;

    function automatic logic [W-1:0] spread(input logic [31:0] d, input logic [4:0] w);
        logic [PW-1:0] t;
        t = PW'(d) << (int'(w) * 32);
        return t[W-1:0];
    endfunction

    function automatic logic [31:0] pick(input logic [W-1:0] v, input logic [4:0] w);
        logic [PW-1:0] p;
        p = PW'(v);
        if (int'(w) < NW) return p[int'(w)*32 +: 32];
        return 32'h0;
    endfunction

    assign wd   = spread(wdata, word);
    assign wsel = spread(32'hFFFF_FFFF, word);

    // next register contents
    always_comb begin
        mask_d  = mask;
        sens_d  = sens;
        pol_d   = pol;
        en_d    = en;
        eo_d    = edge_only;
        ack_clr = '0;
        if (take_wr) begin
            case (bsel)
                BK_ACK:  ack_clr = wd;
                BK_MASK: mask_d  = (mask & ~wsel) | wd;
                BK_MSET: mask_d  = mask | wd;
                BK_MCLR: mask_d  = mask & ~wd;
                BK_SENS: sens_d  = (sens & ~wsel) | wd;
                BK_SSET: sens_d  = sens | wd;
                BK_SCLR: sens_d  = sens & ~wd;
                BK_POL:  pol_d   = (pol & ~wsel) | wd;
                BK_PSET: pol_d   = pol | wd;
                BK_PCLR: pol_d   = pol & ~wd;
                BK_CTRL: begin
                    en_d = wdata[CB_EN];
                    eo_d = wdata[CB_EONLY];
                end
                default: ;
            endcase
        end
        status_d = (status & ~ack_clr) | hit;
        if (state == ST_SRST) begin
            mask_d   = '1;
            sens_d   = '0;
            pol_d    = '1;
            en_d     = 1'b0;
            eo_d     = 1'b0;
            status_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask      <= '1;
            sens      <= '0;
            pol       <= '1;
            en        <= 1'b0;
            edge_only <= 1'b0;
            status    <= '0;
        end else begin
            mask      <= mask_d;
            sens      <= sens_d;
            pol       <= pol_d;
            en        <= en_d;
            edge_only <= eo_d;
            status    <= status_d;
        end
    end

    // read mux
    always_comb begin
        case (bsel)
            BK_STAT:                   rmux = pick(status, word);
            BK_MASK, BK_MSET, BK_MCLR: rmux = pick(mask, word);
            BK_SENS, BK_SSET, BK_SCLR: rmux = pick(sens, word);
            BK_POL,  BK_PSET, BK_PCLR: rmux = pick(pol, word);
            BK_CTRL: rmux = {(|status), 10'b0, 1'b0, 17'b0, 1'b0, edge_only, en};
            default:                   rmux = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          rdata <= 32'h0;
        else if ((state == ST_IDLE) && rd)   rdata <= rmux;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr && (bsel == BK_CTRL) && wdata[CB_SRST])
                    state_nx = ST_SRST;
                else if (wr && (bsel == BK_CTRL) && wdata[CB_FLUSH])
                    state_nx = ST_FLUSH;
                else if (wr || rd)
                    state_nx = ST_RESP;
            end
            ST_FLUSH: state_nx = ST_RESP;
            ST_SRST:  state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready       = 1'b0;
        flush_pulse = 1'b0;
        srst_fire   = 1'b0;
        pending     = '0;
        unique case (state)
            ST_IDLE:  ;
            ST_RESP:  ready = 1'b1;
            ST_FLUSH: begin
                flush_pulse = 1'b1;
                pending     = status;
            end
            ST_SRST:  srst_fire = 1'b1;
        endcase
    end
endmodule

// File: rtl/wake_irq_catcher.sv
module wake_irq_catcher #(
    parameter int NUM_LINES = 439
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_ready,
    output logic                 wake_o,
    output logic                 flush_pulse_o,
    output logic [NUM_LINES-1:0] pending_o
);
    logic [NUM_LINES-1:0] lvl_sync, hit_vec, mask_vec, sens_vec, pol_vec, status_vec;
    logic en_bit, eonly_bit, srst_fire;

    wic_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(irq_in), .q(lvl_sync)
    );

    wic_detect #(.W(NUM_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl(lvl_sync), .en(en_bit),
        .edge_only(eonly_bit), .mask(mask_vec), .sens(sens_vec),
        .pol(pol_vec), .hit(hit_vec)
    );

    wic_regs #(.W(NUM_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .rd(reg_rd), .wr(reg_wr),
        .addr(reg_addr), .wdata(reg_wdata), .hit(hit_vec),
        .rdata(reg_rdata), .ready(reg_ready), .mask(mask_vec),
        .sens(sens_vec), .pol(pol_vec), .en(en_bit),
        .edge_only(eonly_bit), .status(status_vec),
        .flush_pulse(flush_pulse_o), .pending(pending_o),
        .srst_fire(srst_fire)
    );

    assign wake_o = |status_vec;
endmodule

// File: rtl/wic_checker.sv
module wic_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] status,
    input logic [W-1:0] mask,
    input logic         en,
    input logic         flush_pulse,
    input logic [W-1:0] pending,
    input logic         ready,
    input logic         srst_fire
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_gated_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> ((status & ~$past(status) & ($past(mask) | {W{~$past(en)}})) == '0));

    p_flush_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |=> !flush_pulse);

    p_pending_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flush_pulse |-> (pending == '0));

    p_srst_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fire |=> ((status == '0) && (mask == '1) && !en));

    p_ready_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
endmodule

bind wake_irq_catcher wic_checker #(.W(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status_vec), .mask(mask_vec),
    .en(en_bit), .flush_pulse(flush_pulse_o), .pending(pending_o),
    .ready(reg_ready), .srst_fire(srst_fire)
);

// File: tb/wake_irq_catcher_tb.sv
module wake_irq_catcher_tb;
    localparam int N = 439;
    localparam logic [11:0] A_STAT = 12'h000, A_ACK = 12'h080, A_MASK = 12'h100,
        A_MSET = 12'h180, A_MCLR = 12'h200, A_SENS = 12'h280, A_SSET = 12'h300,
        A_SCLR = 12'h380, A_POL = 12'h400, A_PCLR = 12'h500, A_CTRL = 12'h600;

    logic clk = 0, rst_n = 0;
    logic [N-1:0] irq_in = '0;
    logic reg_rd = 0, reg_wr = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic reg_ready, wake_o, flush_pulse_o;
    logic [N-1:0] pending_o;

    int checks = 0, errors = 0, lat = 0;
    bit done = 0, seen_flush = 0, seen_p0 = 0, seen_p1 = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    wake_irq_catcher #(.NUM_LINES(N)) u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus(input bit w, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = w; reg_rd = !w; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0;
        lat = 1; seen_flush = 0; seen_p0 = 0; seen_p1 = 0;
        while (!reg_ready) begin
            if (flush_pulse_o) begin
                seen_flush = 1; seen_p0 = pending_o[0]; seen_p1 = pending_o[1];
            end
            @(negedge clk);
            lat++;
        end
        rv = reg_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d); bus(1, a, d); endtask
    task automatic rd(input logic [11:0] a); bus(0, a, 32'h0); endtask
    task automatic wait_cyc(input int n); repeat (n) @(negedge clk); endtask

    task automatic t_reset;
        rd(A_STAT);          chk("R1 status", rv, 32'h0);
        rd(A_MASK);          chk("R1 mask w0", rv, 32'hFFFF_FFFF);
        rd(A_MASK + 12'd52); chk("R2 mask w13 zero fill", rv, 32'h007F_FFFF);
        rd(A_SENS);          chk("R1 sens", rv, 32'h0);
        rd(A_POL);           chk("R1 pol", rv, 32'hFFFF_FFFF);
        rd(A_CTRL);          chk("R1 ctrl", rv, 32'h0);
        chk("R1 wake", {31'h0, wake_o}, 32'h0);
    endtask

    task automatic t_bus;
        wr(A_STAT, 32'hFFFF_FFFF); chk("R11 ready latency", lat, 1);
        rd(A_STAT); chk("R11 status write ignored", rv, 32'h0);
        wr(12'h700, 32'hFFFF_FFFF);
        rd(A_MASK); chk("R11 unmapped write ignored", rv, 32'hFFFF_FFFF);
    endtask

    task automatic t_alias;
        wr(A_MCLR + 12'd8, 32'h0000_000F);
        rd(A_MASK + 12'd8); chk("R3 clear alias", rv, 32'hFFFF_FFF0);
        wr(A_MSET + 12'd8, 32'h0000_0001);
        rd(A_MCLR + 12'd8); chk("R3 set alias readback", rv, 32'hFFFF_FFF1);
        wr(A_MASK + 12'd8, 32'h1234_5678);
        rd(A_MASK + 12'd8); chk("R3 base replace", rv, 32'h1234_5678);
        wr(A_MSET + 12'd8, 32'hFFFF_FFFF);
        wr(A_SSET + 12'd12, 32'h0000_00A0);
        wr(A_SCLR + 12'd12, 32'h0000_0020);
        rd(A_SENS + 12'd12); chk("R3 sens set/clear", rv, 32'h0000_0080);
        wr(A_SCLR + 12'd12, 32'hFFFF_FFFF);
        wr(A_POL + 12'd52, 32'hFFFF_FFFF);
        rd(A_POL + 12'd52); chk("R2 upper bits zero", rv, 32'h007F_FFFF);
    endtask

    task automatic t_gate;
        wr(A_CTRL, 32'h1);
        @(negedge clk); irq_in[438] = 1; wait_cyc(6);
        rd(A_STAT + 12'd52); chk("R4 masked line no capture", rv, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_MCLR + 12'd52, 32'h0040_0000);
        @(negedge clk); irq_in[438] = 0; wait_cyc(4);
        irq_in[438] = 1; wait_cyc(6);
        rd(A_STAT + 12'd52); chk("R4 disabled no capture", rv, 32'h0);
        wr(A_CTRL, 32'h1);
        @(negedge clk); irq_in[438] = 0; wait_cyc(4);
        irq_in[438] = 1; wait_cyc(6);
        rd(A_STAT + 12'd52); chk("R2 line 438 word13 bit22", rv, 32'h0040_0000);
        chk("R8 wake", {31'h0, wake_o}, 32'h1);
        rd(A_CTRL); chk("R8 event flag", rv, 32'h8000_0001);
        wr(A_ACK + 12'd52, 32'h0040_0000); wait_cyc(3);
        rd(A_STAT + 12'd52); chk("R7 ack clears", rv, 32'h0);
        chk("R8 wake low", {31'h0, wake_o}, 32'h0);
        @(negedge clk); irq_in[438] = 0; wait_cyc(6);
    endtask

    task automatic t_edge;
        wr(A_MCLR + 12'd4, 32'h2);
        @(negedge clk); irq_in[33] = 1; wait_cyc(6);
        rd(A_STAT + 12'd4); chk("R5 rising captured", rv, 32'h2);
        wr(A_ACK + 12'd4, 32'h2); wait_cyc(4);
        rd(A_STAT + 12'd4); chk("R5 steady high no recapture", rv, 32'h0);
        @(negedge clk); irq_in[33] = 0; wait_cyc(6);
        rd(A_STAT + 12'd4); chk("R5 falling ignored rising pol", rv, 32'h0);
        wr(A_PCLR + 12'd4, 32'h2);
        @(negedge clk); irq_in[33] = 1; wait_cyc(6);
        rd(A_STAT + 12'd4); chk("R5 rising ignored falling pol", rv, 32'h0);
        @(negedge clk); irq_in[33] = 0; wait_cyc(6);
        rd(A_STAT + 12'd4); chk("R5 falling captured", rv, 32'h2);
        wr(A_ACK + 12'd4, 32'h2);
        wr(A_MSET + 12'd4, 32'h2);
    endtask

    task automatic t_level;
        wr(A_SSET, 32'h1);
        wr(A_MCLR, 32'h1);
        @(negedge clk); irq_in[0] = 1; wait_cyc(6);
        rd(A_STAT); chk("R6 level captured", rv, 32'h1);
        wr(A_ACK, 32'h1); wait_cyc(2);
        rd(A_STAT); chk("R7 event wins over ack", rv, 32'h1);
        wr(A_CTRL, 32'h3);
        wr(A_ACK, 32'h1); wait_cyc(3);
        rd(A_STAT); chk("R6 edge-only overrides level", rv, 32'h0);
        wr(A_CTRL, 32'h1); wait_cyc(3);
        rd(A_STAT); chk("R6 level resumes", rv, 32'h1);
    endtask

    task automatic t_flush;
        chk("R9 pending idle zero", {31'h0, |pending_o}, 32'h0);
        wr(A_CTRL, 32'h5);
        chk("R9 flush pulse seen", {31'h0, seen_flush}, 32'h1);
        chk("R9 pending shows status", {30'h0, seen_p1, seen_p0}, 32'h1);
        chk("R11 flush latency", lat, 2);
        rd(A_CTRL); chk("R9 flush self-clears", rv, 32'h8000_0001);
    endtask

    task automatic t_srst;
        wr(A_CTRL, 32'h0010_0005);
        chk("R10 no flush with srst", {31'h0, seen_flush}, 32'h0);
        rd(A_CTRL); chk("R10 ctrl cleared", rv, 32'h0);
        rd(A_SENS); chk("R10 sens cleared", rv, 32'h0);
        rd(A_MASK); chk("R10 mask restored", rv, 32'hFFFF_FFFF);
        rd(A_PCLR + 12'd4); chk("R10 pol restored", rv, 32'hFFFF_FFFF);
        rd(A_STAT); chk("R10 status cleared", rv, 32'h0);
        chk("R10 wake low", {31'h0, wake_o}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1;
        wait_cyc(2);
        t_reset();
        t_bus();
        t_alias();
        t_gate();
        t_edge();
        t_level();
        t_flush();
        t_srst();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule